// File: doc/BRIEF.md
# Scheduled Battery-Low Status Monitor

This block decides when the backup battery of a timekeeping device is tested, and keeps the result as a sticky battery-low status bit. A test starts on every power-up event. Further tests start each time a parameterised count of timebase ticks has elapsed, which is about 24 hours at the intended tick rate. A test raises the comparator enable and waits a parameterised number of clock cycles for the comparator to settle. It then captures the one-bit compare result once and drops the enable.

The flag changes only at the capture moment of a completed test. Between tests it holds its value, whatever the comparator does. While the main supply is not nominal, no test starts, a running test is abandoned, and the interval count stands still. An abandoned test remains pending and runs again once the supply returns. When a test completes, one of two single-cycle pulses tells software what kind of test it was. A power-up test that finds the battery low means the stored data is suspect. A periodic test that finds it low means the battery is near the end of its life.

The flag is read through a small register read port. At flags address 0x0F it appears as bit 4.

The test sequencer has three states:
- IDLE: waiting for a pending request.
- SETTLE: comparator enabled, counting settling cycles.
- SAMPLE: comparator enabled, result captured.

The transitions between them are:
- START: IDLE to SETTLE, when a request is pending and the supply is good.
- SETTLED: SETTLE to SAMPLE, after the settling count.
- ABORT: SETTLE or SAMPLE to IDLE, when the supply is lost. In SAMPLE, the loss means no capture.
- FINISH: SAMPLE to IDLE, with the capture.

Top module: `batt_watch`

## Requirements
- R1: After reset, `batt_low`, `cmp_en`, `done_pwrup` and `done_periodic` are 0, and a read of address 0x0F returns 0x00.
- R2: A `pwrup_evt` pulse with the supply good runs one test. Its completion raises `done_pwrup` for exactly one cycle, with `done_periodic` low, and `batt_low` takes the value `cmp_low` had at the capture cycle (1 = battery under threshold).
- R3: During a test, `cmp_en` stays high for SETTLE_CYC+1 consecutive cycles. It falls in the same cycle in which the completion pulse and the new flag value appear.
- R4: With the supply good, the INTERVAL_TICKS-th `tb_tick` since the last restart starts a test that completes with a one-cycle `done_periodic`. One tick fewer starts none.
- R5: Once set, `batt_low` stays 1 while `cmp_low` returns to 0, as long as no test completes.
- R6: A test that captures `cmp_low` = 0 clears `batt_low`.
- R7: While `supply_ok` is 0, `cmp_en` stays 0, the flag does not change, and ticks are not counted. Counting resumes from the paused value.
- R8: A `pwrup_evt` restarts the interval count from zero, so ticks received before it do not count toward the next periodic test.
- R9: A read of address 0x0F returns the flag in bit 4 and zeros elsewhere. Any other address reads 0x00. Reads never change the flag.
- R10: Losing the supply in the middle of a test abandons it: there is no completion pulse and no flag change. The same test runs again once `supply_ok` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| supply_ok | input | 1 | Main supply nominal |
| pwrup_evt | input | 1 | One-cycle power-up event |
| tb_tick | input | 1 | One-cycle prescaled timebase tick |
| cmp_low | input | 1 | Comparator result, 1 = battery under threshold |
| reg_addr | input | ADDR_W | Register read address |
| cmp_en | output | 1 | Comparator enable / sample window |
| batt_low | output | 1 | Sticky battery-low flag |
| done_pwrup | output | 1 | Pulse: a power-up test completed |
| done_periodic | output | 1 | Pulse: a periodic test completed |
| reg_rdata | output | DATA_W | Read data; flag at bit 4 of address 0x0F |

## Verification
The checker watches several properties on every cycle:
- the flag moves only alongside a completion pulse, and then equals the comparator value captured one cycle earlier;
- the two completion pulses never coincide and never last two cycles;
- the enable never stays high after the supply drops;
- every fall of the enable with the supply present comes with a completion.

Only the directed scenarios can show the scheduling itself: the exact tick count that triggers a periodic test, the restart of the count by a power-up, the pause while the supply is down, the retry after an abandoned test, and the read-port decode.

// File: rtl/batt_pkg.sv
package batt_pkg;

    typedef enum logic [1:0] {
        S_IDLE,
        S_SETTLE,
        S_SAMPLE
    } seq_state_t;

    typedef enum logic {
        K_PERIODIC,
        K_PWRUP
    } test_kind_t;

endpackage

// File: rtl/batt_interval_timer.sv
module batt_interval_timer #(
    parameter int INTERVAL_TICKS = 86400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    input  logic tick,
    output logic due
);
    localparam int CNT_W = (INTERVAL_TICKS > 1) ? $clog2(INTERVAL_TICKS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(INTERVAL_TICKS - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            due   <= 1'b0;
        end else begin
            due <= 1'b0;
            if (restart) begin
                cnt_q <= '0;
            end else if (run && tick) begin
                if (cnt_q == LAST) begin
                    cnt_q <= '0;
                    due   <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/batt_test_fsm.sv
module batt_test_fsm
    import batt_pkg::*;
#(
    parameter int SETTLE_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic pwrup_evt,
    input  logic due,
    output logic cmp_en,
    output logic take_sample,
    output logic done_pwrup,
    output logic done_periodic
);
    localparam int SW = $clog2(SETTLE_CYC + 1);
    localparam logic [SW-1:0] SETTLE_LAST = SW'(SETTLE_CYC - 1);

    seq_state_t state_q, state_d;
    test_kind_t kind_q;
    logic [SW-1:0] cnt_q;
    logic pwr_pend_q, per_pend_q;
    logic start;

    assign start = (state_q == S_IDLE) && supply_ok && (pwr_pend_q || per_pend_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // transitions: START, SETTLED, ABORT, FINISH
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start) state_d = S_SETTLE;
            S_SETTLE: begin
                if (!supply_ok)                state_d = S_IDLE;
                else if (cnt_q == SETTLE_LAST) state_d = S_SAMPLE;
            end
            S_SAMPLE: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cmp_en      = 1'b0;
        take_sample = 1'b0;
        unique case (state_q)
            S_IDLE:   ;
            S_SETTLE: cmp_en = 1'b1;
            S_SAMPLE: begin
                cmp_en      = 1'b1;
                take_sample = supply_ok;
            end
            default:  ;
        endcase
    end

    // settle counter, pending requests, test kind, completion pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q         <= '0;
            kind_q        <= K_PERIODIC;
            pwr_pend_q    <= 1'b0;
            per_pend_q    <= 1'b0;
            done_pwrup    <= 1'b0;
            done_periodic <= 1'b0;
        end else begin
            done_pwrup    <= take_sample && (kind_q == K_PWRUP);
            done_periodic <= take_sample && (kind_q == K_PERIODIC);

            if (state_q == S_SETTLE) cnt_q <= cnt_q + 1'b1;
            else                     cnt_q <= '0;

            if (start) kind_q <= pwr_pend_q ? K_PWRUP : K_PERIODIC;

            if (pwrup_evt)
                pwr_pend_q <= 1'b1;
            else if (take_sample && kind_q == K_PWRUP)
                pwr_pend_q <= 1'b0;

            if (pwrup_evt)
                per_pend_q <= 1'b0;
            else if (due)
                per_pend_q <= 1'b1;
            else if (take_sample && kind_q == K_PERIODIC)
                per_pend_q <= 1'b0;
        end
    end
endmodule

// File: rtl/batt_flag_reg.sv
module batt_flag_reg #(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 8,
    parameter int FLAG_ADDR = 15,
    parameter int FLAG_BIT  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_sample,
    input  logic              cmp_low,
    input  logic [ADDR_W-1:0] reg_addr,
    output logic              batt_low,
    output logic [DATA_W-1:0] reg_rdata
);
    localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(FLAG_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           batt_low <= 1'b0;
        else if (take_sample) batt_low <= cmp_low;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == HIT_ADDR) reg_rdata[FLAG_BIT] = batt_low;
    end
endmodule

// File: rtl/batt_watch.sv
module batt_watch #(
    parameter int INTERVAL_TICKS = 86400,
    parameter int SETTLE_CYC     = 4,
    parameter int ADDR_W         = 4,
    parameter int DATA_W         = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              supply_ok,
    input  logic              pwrup_evt,
    input  logic              tb_tick,
    input  logic              cmp_low,
    input  logic [ADDR_W-1:0] reg_addr,
    output logic              cmp_en,
    output logic              batt_low,
    output logic              done_pwrup,
    output logic              done_periodic,
    output logic [DATA_W-1:0] reg_rdata
);
    logic due;
    logic take_sample;

    batt_interval_timer #(.INTERVAL_TICKS(INTERVAL_TICKS)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (supply_ok),
        .restart (pwrup_evt),
        .tick    (tb_tick),
        .due     (due)
    );

    batt_test_fsm #(.SETTLE_CYC(SETTLE_CYC)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .supply_ok     (supply_ok),
        .pwrup_evt     (pwrup_evt),
        .due           (due),
        .cmp_en        (cmp_en),
        .take_sample   (take_sample),
        .done_pwrup    (done_pwrup),
        .done_periodic (done_periodic)
    );

    batt_flag_reg #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .FLAG_ADDR (15),
        .FLAG_BIT  (4)
    ) u_flag (
        .clk         (clk),
        .rst_n       (rst_n),
        .take_sample (take_sample),
        .cmp_low     (cmp_low),
        .reg_addr    (reg_addr),
        .batt_low    (batt_low),
        .reg_rdata   (reg_rdata)
    );
endmodule

// File: rtl/batt_watch_chk.sv
module batt_watch_chk (
    input logic clk,
    input logic rst_n,
    input logic supply_ok,
    input logic cmp_low,
    input logic cmp_en,
    input logic batt_low,
    input logic done_pwrup,
    input logic done_periodic
);
    // R5
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(batt_low) |-> (done_pwrup || done_periodic));

    // R2
    flag_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_pwrup || done_periodic) |-> (batt_low == $past(cmp_low)));

    // R2
    kind_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_pwrup, done_periodic}));

    // R3
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_pwrup || done_periodic) |=> !(done_pwrup || done_periodic));

    // R3
    en_fall_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cmp_en) && $past(supply_ok)) |-> (done_pwrup || done_periodic));

    // R7
    no_test_unpowered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> !cmp_en);
endmodule

bind batt_watch batt_watch_chk i_batt_watch_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .supply_ok     (supply_ok),
    .cmp_low       (cmp_low),
    .cmp_en        (cmp_en),
    .batt_low      (batt_low),
    .done_pwrup    (done_pwrup),
    .done_periodic (done_periodic)
);

// File: tb/test_batt_watch.sv
`timescale 1ns/1ps
module test_batt_watch;
    localparam int INTERVAL = 10;
    localparam int SETTLE   = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b0;
    logic pwrup_evt = 1'b0;
    logic tb_tick = 1'b0;
    logic cmp_low = 1'b0;
    logic [3:0] reg_addr = 4'hF;
    logic cmp_en, batt_low, done_pwrup, done_periodic;
    logic [7:0] reg_rdata;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    batt_watch #(.INTERVAL_TICKS(INTERVAL), .SETTLE_CYC(SETTLE)) i_batt_watch (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .pwrup_evt(pwrup_evt),
        .tb_tick(tb_tick), .cmp_low(cmp_low), .reg_addr(reg_addr),
        .cmp_en(cmp_en), .batt_low(batt_low), .done_pwrup(done_pwrup),
        .done_periodic(done_periodic), .reg_rdata(reg_rdata)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    task automatic pulse_pwrup();
        @(negedge clk) pwrup_evt = 1'b1;
        @(negedge clk) pwrup_evt = 1'b0;
    endtask

    // apply n ticks; return how many cycles cmp_en or a done pulse was seen
    task automatic ticks(input int n, output int activity);
        activity = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tb_tick = 1'b1;
            if (cmp_en || done_pwrup || done_periodic) activity++;
            @(negedge clk) tb_tick = 1'b0;
            if (cmp_en || done_pwrup || done_periodic) activity++;
            repeat (2) begin
                @(negedge clk);
                if (cmp_en || done_pwrup || done_periodic) activity++;
            end
        end
    endtask

    task automatic wait_done(output int en_cycles, output bit pw, output bit per);
        en_cycles = 0; pw = 0; per = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (done_pwrup || done_periodic) begin
                pw = done_pwrup; per = done_periodic;
                break;
            end
            if (cmp_en) en_cycles++;
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 flag", batt_low, 0);
        check("R1 cmp_en", cmp_en, 0);
        check("R1 done", done_pwrup | done_periodic, 0);
        reg_addr = 4'hF; #1;
        check("R1 read 0x0F", reg_rdata, 8'h00);
        rst_n = 1'b1; supply_ok = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_pwrup_low();
        int en; bit pw, per;
        cmp_low = 1'b1;
        pulse_pwrup();
        wait_done(en, pw, per);
        check("R2 done_pwrup", pw, 1);
        check("R2 done_periodic", per, 0);
        check("R2 flag set", batt_low, 1);
        check("R3 enable cycles", en, SETTLE + 1);
        check("R3 enable low at done", cmp_en, 0);
        @(negedge clk);
        check("R2 pulse single", done_pwrup, 0);
        reg_addr = 4'hF; #1;
        check("R9 read 0x0F", reg_rdata, 8'h10);
        reg_addr = 4'h3; #1;
        check("R9 read other", reg_rdata, 8'h00);
        reg_addr = 4'hE; #1;
        check("R9 read 0x0E", reg_rdata, 8'h00);
    endtask

    task automatic t_sticky();
        cmp_low = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk) reg_addr = (i % 2) ? 4'hF : 4'h1;
        end
        check("R5 flag sticky", batt_low, 1);
        reg_addr = 4'hF; #1;
        check("R9 reads keep flag", reg_rdata, 8'h10);
    endtask

    task automatic t_periodic_clear();
        int act, en; bit pw, per;
        ticks(INTERVAL - 1, act);
        check("R4 no test before interval", act, 0);
        ticks(1, act);
        wait_done(en, pw, per);
        check("R4 done_periodic", per, 1);
        check("R4 not pwrup", pw, 0);
        check("R6 flag cleared", batt_low, 0);
    endtask

    task automatic t_pwrup_restart();
        int act, en; bit pw, per;
        ticks(6, act);
        cmp_low = 1'b0;
        pulse_pwrup();
        wait_done(en, pw, per);
        check("R8 pwrup test", pw, 1);
        ticks(INTERVAL - 1, act);
        check("R8 earlier ticks discarded", act, 0);
        cmp_low = 1'b1;
        ticks(1, act);
        wait_done(en, pw, per);
        check("R8 periodic after full interval", per, 1);
        check("R6 periodic sets flag", batt_low, 1);
    endtask

    task automatic t_supply_pause();
        int act, en; bit pw, per;
        cmp_low = 1'b0;
        ticks(5, act);
        supply_ok = 1'b0;
        ticks(8, act);
        check("R7 no enable while down", act, 0);
        check("R7 flag unchanged", batt_low, 1);
        supply_ok = 1'b1;
        ticks(4, act);
        check("R7 count paused", act, 0);
        ticks(1, act);
        wait_done(en, pw, per);
        check("R7 resumed periodic", per, 1);
        check("R7 flag updated after resume", batt_low, 0);
    endtask

    task automatic t_abort();
        int en; bit pw, per; int seen;
        cmp_low = 1'b1;
        pulse_pwrup();
        for (int i = 0; i < 10 && !cmp_en; i++) @(negedge clk);
        @(negedge clk) supply_ok = 1'b0;
        seen = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (done_pwrup || done_periodic) seen++;
        end
        check("R10 no completion on abort", seen, 0);
        check("R10 flag unchanged", batt_low, 0);
        check("R10 enable dropped", cmp_en, 0);
        supply_ok = 1'b1;
        wait_done(en, pw, per);
        check("R10 retried pwrup test", pw, 1);
        check("R10 flag after retry", batt_low, 1);
    endtask

    initial begin
        t_reset();
        t_pwrup_low();
        t_sticky();
        t_periodic_clear();
        t_pwrup_restart();
        t_supply_pause();
        t_abort();
        repeat (5) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule